// File: doc/BRIEF.md
# SD SPI-Mode Initialization Sequencer

This block brings a memory card that speaks the SPI-mode command protocol from power-up to a ready state, then classifies it. It runs the whole bring-up from one start pulse. It first requests a run of filler bytes with chip select released. It then issues a fixed but branching series of commands through a command-engine handshake. This series covers the reset command with retries, the interface-condition probe, the voltage-window check, the operating-condition polling loop, the capacity read and the block-length setup. Byte shifting, CRC generation and data transfers stay in the command engine, which sits outside this block.

The command engine receives a command index, a 32-bit argument, an application-command flag and a one-cycle start pulse. When the exchange is complete it returns a one-cycle done pulse, the R1 status byte and the 32-bit trailing response. At the end of a run the sequencer raises either `init_done` or `init_err`. It also reports a card-type code, a 2-bit error code and whether the card takes block addresses instead of byte addresses. The slow-clock enable stays high until the sequence finishes successfully.

Top module: `sd_init_seq`

## Requirements
- R1: An accepted start first produces exactly FILL_BYTES (default 10) `fill_start` requests, each acknowledged by `fill_done`. `cs_n` stays high throughout these requests, and no command is issued before they are complete.
- R2: Command 0 is sent with argument 0. It is repeated up to RESET_TRIES (default 5) times, with at least PAUSE_CYCLES cycles between attempts, until R1 equals exactly 0x01. If every attempt fails, the block raises `init_err` with `err_code` 0 (no device) and `card_type` 0 (none).
- R3: Command 8 is then sent with argument 0x1AA. If R1 bit 2 (illegal command) is set, the card takes the legacy path. Otherwise, bits 11:0 of the trailing response must equal 0x1AA; if they do not, the block raises `init_err` with `err_code` 1 (unusable) and `card_type` 4 (unknown).
- R4: Command 58 is then sent with argument 0. If bit 20 of its trailing response is clear, the block raises `init_err` with `err_code` 1 and `card_type` 4.
- R5: Command 41 is sent with `cmd_app` = 1, and no other command sets `cmd_app`. Its argument is 0x40000000 after a successful command 8 and 0 on the legacy path. It is repeated while R1 bit 0 is set. If it is still busy after POLL_MAX attempts, the block raises `init_err` with `err_code` 2 (timeout) and `card_type` 4. If the returned R1 has bit 0 clear but is not 0x00, the block raises `err_code` 3 (command failed) with `card_type` 4.
- R6: On the legacy path, `card_type` becomes 1 and no second command 58 is sent. On the newer path, a second command 58 follows. If response bit 30 is set, `card_type` becomes 3 and `block_addr` becomes 1; otherwise `card_type` becomes 2 and `block_addr` becomes 0.
- R7: Command 16 is sent last, with argument BLOCK_LEN (default 512). An R1 of 0x00 raises `init_done`. Any other R1 value raises `init_err` with `err_code` 3.
- R8: `slow_clk_en` is 1 after reset and after every accepted start. It falls only in the cycle in which `init_done` rises.
- R9: A start pulse is accepted only while no sequence is running; pulses during a run change neither the command order nor the filler count. An accepted start clears `init_done` and `init_err` and reruns the whole sequence from the filler bytes.
- R10: `init_done` and `init_err` are never both high, and each holds until the next accepted start. After reset, `cs_n` = 1, `init_done` = 0, `init_err` = 0, `card_type` = 0, and no request strobe is active. `card_type` never exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the bring-up sequence (accepted when idle) |
| cs_n | output | 1 | Card chip select, active low |
| slow_clk_en | output | 1 | Request for the low-rate bring-up clock |
| fill_start | output | 1 | One-cycle request for a filler byte (0xFF) |
| fill_done | input | 1 | Filler byte completed |
| cmd_start | output | 1 | One-cycle request to issue a command |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_app | output | 1 | Precede the command with the application-command prefix |
| cmd_done | input | 1 | Command exchange completed; response inputs valid |
| cmd_r1 | input | 8 | R1 status byte |
| cmd_resp | input | 32 | Trailing 32-bit response |
| init_done | output | 1 | Sequence completed successfully |
| init_err | output | 1 | Sequence failed |
| err_code | output | 2 | 0 no device, 1 unusable, 2 timeout, 3 command failed |
| card_type | output | 3 | 0 none, 1 v1 standard, 2 v2 standard, 3 v2 high capacity, 4 unknown |
| block_addr | output | 1 | Card uses block addressing |

## Verification
The assertions assume the command engine pulses `fill_done` and `cmd_done` for one cycle only, and only after the matching request. They also assume the R1 byte and trailing response are valid in the same cycle as `cmd_done`, and that `start` is a single-cycle pulse. The bench's card model keeps to these rules. It acknowledges each filler request one cycle after it is seen and answers each command a fixed two cycles later. It decides each answer from the command index and its own per-scenario settings, never from the design's internal state.

// File: rtl/sd_init_pkg.sv
package sd_init_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL_REQ,
        ST_FILL_WAIT,
        ST_CMD_REQ,
        ST_CMD_WAIT,
        ST_EVAL,
        ST_PAUSE
    } seq_state_t;

    typedef enum logic [2:0] {
        STEP_RESET,
        STEP_IFCOND,
        STEP_OCR_PRE,
        STEP_OPCOND,
        STEP_OCR_POST,
        STEP_BLKLEN
    } seq_step_t;

    typedef enum logic [2:0] {
        CT_NONE    = 3'd0,
        CT_V1      = 3'd1,
        CT_V2_STD  = 3'd2,
        CT_V2_HIGH = 3'd3,
        CT_UNKNOWN = 3'd4
    } card_kind_t;

    typedef enum logic [1:0] {
        EC_NODEV    = 2'd0,
        EC_UNUSABLE = 2'd1,
        EC_TIMEOUT  = 2'd2,
        EC_CMDFAIL  = 2'd3
    } fail_code_t;

    typedef struct packed {
        logic [5:0]  index;
        logic [31:0] arg;
        logic        app;
    } cmd_desc_t;

    localparam logic [31:0] IFCOND_ARG   = 32'h0000_01AA;
    localparam logic [31:0] HOST_CAP_ARG = 32'h4000_0000;
    localparam logic [7:0]  R1_IDLE      = 8'h01;
    localparam logic [7:0]  R1_READY     = 8'h00;
    localparam int          R1_ILLEGAL   = 2;
    localparam int          R1_BUSY      = 0;

    function automatic logic echo_matches(input logic [11:0] low_bits);
        return low_bits == IFCOND_ARG[11:0];
    endfunction

    function automatic logic [31:0] opcond_arg(input logic newer_card);
        return newer_card ? HOST_CAP_ARG : 32'h0;
    endfunction

endpackage

// File: rtl/sdi_counter.sv
module sdi_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/sdi_cmd_table.sv
module sdi_cmd_table
    import sd_init_pkg::*;
#(
    parameter int BLOCK_LEN = 512
) (
    input  seq_step_t step,
    input  logic      newer_card,
    output cmd_desc_t desc
);
    always_comb begin
        desc = '{index: 6'd0, arg: 32'h0, app: 1'b0};
        unique case (step)
            STEP_RESET:    desc = '{index: 6'd0,  arg: 32'h0,              app: 1'b0};
            STEP_IFCOND:   desc = '{index: 6'd8,  arg: IFCOND_ARG,         app: 1'b0};
            STEP_OCR_PRE,
            STEP_OCR_POST: desc = '{index: 6'd58, arg: 32'h0,              app: 1'b0};
            STEP_OPCOND:   desc = '{index: 6'd41, arg: opcond_arg(newer_card), app: 1'b1};
            STEP_BLKLEN:   desc = '{index: 6'd16, arg: 32'(BLOCK_LEN),     app: 1'b0};
            default:       desc = '{index: 6'd0,  arg: 32'h0,              app: 1'b0};
        endcase
    end
endmodule

// File: rtl/sd_init_seq.sv
module sd_init_seq
    import sd_init_pkg::*;
#(
    parameter int FILL_BYTES   = 10,
    parameter int RESET_TRIES  = 5,
    parameter int PAUSE_CYCLES = 1000,
    parameter int POLL_MAX     = 1000,
    parameter int BLOCK_LEN    = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    output logic        cs_n,
    output logic        slow_clk_en,
    output logic        fill_start,
    input  logic        fill_done,
    output logic        cmd_start,
    output logic [5:0]  cmd_index,
    output logic [31:0] cmd_arg,
    output logic        cmd_app,
    input  logic        cmd_done,
    input  logic [7:0]  cmd_r1,
    input  logic [31:0] cmd_resp,
    output logic        init_done,
    output logic        init_err,
    output logic [1:0]  err_code,
    output logic [2:0]  card_type,
    output logic        block_addr
);
    localparam int FILL_W  = $clog2(FILL_BYTES + 1);
    localparam int TRY_W   = $clog2(RESET_TRIES + 1);
    localparam int PAUSE_W = $clog2(PAUSE_CYCLES + 1);
    localparam int POLL_W  = $clog2(POLL_MAX + 1);

    seq_state_t state;
    seq_step_t  step;
    logic [7:0] r1_q;
    logic       echo_ok_q, v33_q, ccs_q;
    logic       newer_q;
    card_kind_t kind_q;
    fail_code_t code_q;
    logic       done_q, err_q, slow_q, blk_q;

    logic [FILL_W-1:0]  fill_cnt;
    logic [TRY_W-1:0]   try_cnt;
    logic [PAUSE_W-1:0] pause_cnt;
    logic [POLL_W-1:0]  poll_cnt;

    logic start_ok;
    logic in_eval;
    logic reset_miss, poll_busy;
    cmd_desc_t desc;

    logic unused_resp_bits;
    assign unused_resp_bits = ^{cmd_resp[31], cmd_resp[29:21], cmd_resp[19:12]};

    assign start_ok   = start && (state == ST_IDLE);
    assign in_eval    = (state == ST_EVAL);
    assign reset_miss = in_eval && (step == STEP_RESET) && (r1_q != R1_IDLE);
    assign poll_busy  = in_eval && (step == STEP_OPCOND) && r1_q[R1_BUSY];

    // filler bytes acknowledged in this run (R1)
    sdi_counter #(.W(FILL_W)) u_fill_cnt (
        .clk(clk), .rst(rst), .clr(start_ok),
        .inc((state == ST_FILL_WAIT) && fill_done), .count(fill_cnt)
    );

    // failed reset attempts (R2)
    sdi_counter #(.W(TRY_W)) u_try_cnt (
        .clk(clk), .rst(rst), .clr(start_ok),
        .inc(reset_miss), .count(try_cnt)
    );

    // gap between reset attempts (R2)
    sdi_counter #(.W(PAUSE_W)) u_pause_cnt (
        .clk(clk), .rst(rst), .clr(state != ST_PAUSE),
        .inc(state == ST_PAUSE), .count(pause_cnt)
    );

    // busy replies to the operating-condition command (R5)
    sdi_counter #(.W(POLL_W)) u_poll_cnt (
        .clk(clk), .rst(rst), .clr(start_ok),
        .inc(poll_busy), .count(poll_cnt)
    );

    sdi_cmd_table #(.BLOCK_LEN(BLOCK_LEN)) u_table (
        .step(step), .newer_card(newer_q), .desc(desc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            step      <= STEP_RESET;
            r1_q      <= '0;
            echo_ok_q <= 1'b0;
            v33_q     <= 1'b0;
            ccs_q     <= 1'b0;
            newer_q   <= 1'b0;
            kind_q    <= CT_NONE;
            code_q    <= EC_NODEV;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            slow_q    <= 1'b1;
            blk_q     <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        done_q  <= 1'b0;
                        err_q   <= 1'b0;
                        code_q  <= EC_NODEV;
                        kind_q  <= CT_NONE;
                        blk_q   <= 1'b0;
                        slow_q  <= 1'b1;
                        newer_q <= 1'b0;
                        step    <= STEP_RESET;
                        state   <= ST_FILL_REQ;
                    end
                end
                ST_FILL_REQ: state <= ST_FILL_WAIT;
                ST_FILL_WAIT: begin
                    if (fill_done) begin
                        if (fill_cnt == FILL_W'(FILL_BYTES - 1)) begin
                            state <= ST_CMD_REQ;
                        end else begin
                            state <= ST_FILL_REQ;
                        end
                    end
                end
                ST_CMD_REQ: state <= ST_CMD_WAIT;
                ST_CMD_WAIT: begin
                    if (cmd_done) begin
                        r1_q      <= cmd_r1;
                        echo_ok_q <= echo_matches(cmd_resp[11:0]);
                        v33_q     <= cmd_resp[20];
                        ccs_q     <= cmd_resp[30];
                        state     <= ST_EVAL;
                    end
                end
                ST_PAUSE: begin
                    if (pause_cnt == PAUSE_W'(PAUSE_CYCLES - 1)) begin
                        state <= ST_CMD_REQ;
                    end
                end
                ST_EVAL: begin
                    unique case (step)
                        STEP_RESET: begin
                            if (r1_q == R1_IDLE) begin
                                step  <= STEP_IFCOND;
                                state <= ST_CMD_REQ;
                            end else if (try_cnt == TRY_W'(RESET_TRIES - 1)) begin
                                err_q  <= 1'b1;
                                code_q <= EC_NODEV;
                                kind_q <= CT_NONE;
                                state  <= ST_IDLE;
                            end else begin
                                state <= ST_PAUSE;
                            end
                        end
                        STEP_IFCOND: begin
                            if (r1_q[R1_ILLEGAL]) begin
                                newer_q <= 1'b0;
                                step    <= STEP_OCR_PRE;
                                state   <= ST_CMD_REQ;
                            end else if (echo_ok_q) begin
                                newer_q <= 1'b1;
                                step    <= STEP_OCR_PRE;
                                state   <= ST_CMD_REQ;
                            end else begin
                                err_q  <= 1'b1;
                                code_q <= EC_UNUSABLE;
                                kind_q <= CT_UNKNOWN;
                                state  <= ST_IDLE;
                            end
                        end
                        STEP_OCR_PRE: begin
                            if (v33_q) begin
                                step  <= STEP_OPCOND;
                                state <= ST_CMD_REQ;
                            end else begin
                                err_q  <= 1'b1;
                                code_q <= EC_UNUSABLE;
                                kind_q <= CT_UNKNOWN;
                                state  <= ST_IDLE;
                            end
                        end
                        STEP_OPCOND: begin
                            if (r1_q == R1_READY) begin
                                if (newer_q) begin
                                    step <= STEP_OCR_POST;
                                end else begin
                                    kind_q <= CT_V1;
                                    step   <= STEP_BLKLEN;
                                end
                                state <= ST_CMD_REQ;
                            end else if (r1_q[R1_BUSY]) begin
                                if (poll_cnt == POLL_W'(POLL_MAX - 1)) begin
                                    err_q  <= 1'b1;
                                    code_q <= EC_TIMEOUT;
                                    kind_q <= CT_UNKNOWN;
                                    state  <= ST_IDLE;
                                end else begin
                                    state <= ST_CMD_REQ;
                                end
                            end else begin
                                err_q  <= 1'b1;
                                code_q <= EC_CMDFAIL;
                                kind_q <= CT_UNKNOWN;
                                state  <= ST_IDLE;
                            end
                        end
                        STEP_OCR_POST: begin
                            kind_q <= ccs_q ? CT_V2_HIGH : CT_V2_STD;
                            blk_q  <= ccs_q;
                            step   <= STEP_BLKLEN;
                            state  <= ST_CMD_REQ;
                        end
                        STEP_BLKLEN: begin
                            if (r1_q == R1_READY) begin
                                done_q <= 1'b1;
                                slow_q <= 1'b0;
                            end else begin
                                err_q  <= 1'b1;
                                code_q <= EC_CMDFAIL;
                            end
                            state <= ST_IDLE;
                        end
                        default: state <= ST_IDLE;
                    endcase
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cs_n        = !((state == ST_CMD_REQ) || (state == ST_CMD_WAIT) ||
                           (state == ST_EVAL)    || (state == ST_PAUSE));
    assign fill_start  = (state == ST_FILL_REQ);
    assign cmd_start   = (state == ST_CMD_REQ);
    assign cmd_index   = desc.index;
    assign cmd_arg     = desc.arg;
    assign cmd_app     = desc.app;
    assign slow_clk_en = slow_q;
    assign init_done   = done_q;
    assign init_err    = err_q;
    assign err_code    = code_q;
    assign card_type   = kind_q;
    assign block_addr  = blk_q;

endmodule

// File: rtl/sd_init_seq_checker.sv
module sd_init_seq_checker #(
    parameter int BLOCK_LEN = 512
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        cs_n,
    input logic        slow_clk_en,
    input logic        fill_start,
    input logic        cmd_start,
    input logic [5:0]  cmd_index,
    input logic [31:0] cmd_arg,
    input logic        cmd_app,
    input logic        init_done,
    input logic        init_err,
    input logic [1:0]  err_code,
    input logic [2:0]  card_type,
    input logic        block_addr
);
    assert_fill_cs_high_R1: assert property (@(posedge clk) disable iff (rst)
        fill_start |-> cs_n);

    assert_fill_not_cmd_R1: assert property (@(posedge clk) disable iff (rst)
        !(fill_start && cmd_start));

    assert_cmd_cs_low_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_start |-> !cs_n);

    assert_nodev_type_R2: assert property (@(posedge clk) disable iff (rst)
        (init_err && err_code == 2'd0) |-> card_type == 3'd0);

    assert_ifcond_arg_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && cmd_index == 6'd8) |-> cmd_arg == 32'h0000_01AA);

    assert_app_flag_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_start |-> (cmd_app == (cmd_index == 6'd41)));

    assert_blk_type_R6: assert property (@(posedge clk) disable iff (rst)
        block_addr |-> card_type == 3'd3);

    assert_blklen_arg_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && cmd_index == 6'd16) |-> cmd_arg == 32'(BLOCK_LEN));

    assert_slow_fall_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(slow_clk_en) |-> init_done);

    assert_done_slow_R8: assert property (@(posedge clk) disable iff (rst)
        init_done |-> !slow_clk_en);

    assert_cmd_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        cmd_start |=> !cmd_start);

    assert_fill_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        fill_start |=> !fill_start);

    assert_done_err_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(init_done && init_err));

    assert_done_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (init_done && !start) |=> init_done);

    assert_type_range_R10: assert property (@(posedge clk) disable iff (rst)
        card_type <= 3'd4);
endmodule

bind sd_init_seq sd_init_seq_checker u_chk (.*);

// File: tb/sd_init_seq_bench.sv
module sd_init_seq_bench;
    localparam int FILL  = 10;
    localparam int TRIES = 5;
    localparam int PAUSE = 4;
    localparam int POLL  = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst, start, fill_done, cmd_done;
    logic [7:0]  cmd_r1;
    logic [31:0] cmd_resp;
    logic        cs_n, slow_clk_en, fill_start, cmd_start, cmd_app;
    logic [5:0]  cmd_index;
    logic [31:0] cmd_arg;
    logic        init_done, init_err, block_addr;
    logic [1:0]  err_code;
    logic [2:0]  card_type;

    sd_init_seq #(.FILL_BYTES(FILL), .RESET_TRIES(TRIES), .PAUSE_CYCLES(PAUSE),
                  .POLL_MAX(POLL), .BLOCK_LEN(512)) u_sd_init_seq (
        .clk(clk), .rst(rst), .start(start), .cs_n(cs_n), .slow_clk_en(slow_clk_en),
        .fill_start(fill_start), .fill_done(fill_done), .cmd_start(cmd_start),
        .cmd_index(cmd_index), .cmd_arg(cmd_arg), .cmd_app(cmd_app),
        .cmd_done(cmd_done), .cmd_r1(cmd_r1), .cmd_resp(cmd_resp),
        .init_done(init_done), .init_err(init_err), .err_code(err_code),
        .card_type(card_type), .block_addr(block_addr)
    );

    typedef struct packed {
        logic [5:0]  idx;
        logic [31:0] arg;
        logic        app;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0, fails = 0, cyc = 0, fills = 0, last0 = -1;

    // card model settings
    int          cfg_f0, cfg_busy, cfg_legacy;
    logic [31:0] cfg_echo, cfg_opre, cfg_opost;
    logic [7:0]  cfg_afin, cfg_r16;
    int          n_cmd0, n_acmd, n_ocr;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    function automatic string req_of(input logic [5:0] idx);
        case (idx)
            6'd0:    return "R2";
            6'd8:    return "R3";
            6'd58:   return "R4";
            6'd41:   return "R5";
            6'd16:   return "R7";
            default: return "R9";
        endcase
    endfunction

    // filler byte responder
    initial begin
        logic pend;
        pend = 1'b0;
        fill_done = 1'b0;
        forever begin
            @(negedge clk);
            fill_done = pend;
            pend = fill_start;
        end
    end

    // command responder
    initial begin
        logic [7:0]  r;
        logic [31:0] d;
        cmd_done = 1'b0;
        cmd_r1 = 8'h0;
        cmd_resp = 32'h0;
        forever begin
            @(negedge clk);
            if (cmd_start) begin
                r = 8'h00;
                d = 32'h0;
                case (cmd_index)
                    6'd0: begin
                        r = (n_cmd0 < cfg_f0) ? 8'hFF : 8'h01;
                        n_cmd0++;
                    end
                    6'd8: begin
                        if (cfg_legacy != 0) r = 8'h05;
                        else begin r = 8'h01; d = cfg_echo; end
                    end
                    6'd58: begin
                        d = (n_ocr == 0) ? cfg_opre : cfg_opost;
                        n_ocr++;
                    end
                    6'd41: begin
                        r = (cfg_busy < 0 || n_acmd < cfg_busy) ? 8'h01 : cfg_afin;
                        n_acmd++;
                    end
                    6'd16: r = cfg_r16;
                    default: r = 8'h04;
                endcase
                repeat (2) @(negedge clk);
                cmd_r1 = r;
                cmd_resp = d;
                cmd_done = 1'b1;
                @(negedge clk);
                cmd_done = 1'b0;
            end
        end
    end

    // scoreboard monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (fill_start) begin
                chk(cs_n === 1'b1, "R1 cs_n high during filler", 32'(cs_n), 32'd1);
                fills++;
            end
            if (cmd_start) begin
                chk(fills == FILL, "R1 filler count before command", fills, FILL);
                if (cmd_index == 6'd0) begin
                    if (last0 >= 0)
                        chk((cyc - last0) > PAUSE, "R2 pause between reset attempts",
                            cyc - last0, PAUSE + 1);
                    last0 = cyc;
                end
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected command", 32'(cmd_index), 32'hFFFF_FFFF);
                end else begin
                    e = exp_q.pop_front();
                    chk(cmd_index == e.idx && cmd_app == e.app,
                        {req_of(e.idx), " command index/app"},
                        {25'd0, cmd_app, cmd_index}, {25'd0, e.app, e.idx});
                    chk(cmd_arg == e.arg, {req_of(e.idx), " command argument"},
                        cmd_arg, e.arg);
                end
            end
        end
    end

    // watchdog
    initial begin
        wait (cyc >= 150000);
        checks++;
        fails++;
        $display("FAIL R10 watchdog expired actual=%0d expected=<150000", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    task automatic set_card(input int f0, input int legacy, input logic [31:0] echo,
                            input logic [31:0] opre, input int busy,
                            input logic [7:0] afin, input logic [31:0] opost,
                            input logic [7:0] r16);
        cfg_f0 = f0; cfg_legacy = legacy; cfg_echo = echo; cfg_opre = opre;
        cfg_busy = busy; cfg_afin = afin; cfg_opost = opost; cfg_r16 = r16;
        n_cmd0 = 0; n_acmd = 0; n_ocr = 0;
    endtask

    task automatic push(input logic [5:0] idx, input logic [31:0] arg, input logic app);
        exp_t e;
        e.idx = idx; e.arg = arg; e.app = app;
        exp_q.push_back(e);
    endtask

    task automatic push_n(input int n, input logic [5:0] idx, input logic [31:0] arg,
                          input logic app);
        for (int i = 0; i < n; i++) push(idx, arg, app);
    endtask

    task automatic launch();
        fills = 0;
        last0 = -1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        int n;
        n = 0;
        while (!(init_done || init_err) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        chk(exp_q.size() == 0, "R9 all expected commands issued", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic expect_end(input string req, input logic d, input logic er,
                              input logic [1:0] code, input logic [2:0] ty,
                              input logic blk, input logic slow);
        chk(init_done == d && init_err == er, {req, " done/err"},
            {30'd0, init_done, init_err}, {30'd0, d, er});
        if (er) chk(err_code == code, {req, " err_code"}, 32'(err_code), 32'(code));
        chk(card_type == ty, {req, " card_type"}, 32'(card_type), 32'(ty));
        chk(block_addr == blk, {req, " block_addr"}, 32'(block_addr), 32'(blk));
        chk(slow_clk_en == slow, "R8 slow_clk_en at end", 32'(slow_clk_en), 32'(slow));
        chk(cs_n == 1'b1, "R10 cs_n high when idle", 32'(cs_n), 32'd1);
    endtask

    initial begin
        rst = 1'b1;
        start = 1'b0;
        set_card(0, 0, 32'h1AA, 32'h00FF8000, 0, 8'h00, 32'h00FF8000, 8'h00);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(cs_n == 1'b1 && !init_done && !init_err, "R10 reset cs_n/done/err",
            {29'd0, cs_n, init_done, init_err}, 32'h4);
        chk(card_type == 3'd0, "R10 reset card_type", 32'(card_type), 0);
        chk(!cmd_start && !fill_start, "R10 reset strobes idle",
            {30'd0, cmd_start, fill_start}, 0);
        chk(slow_clk_en == 1'b1, "R8 slow clock after reset", 32'(slow_clk_en), 1);

        // A: newer high-capacity card, two lost resets, start pulse mid-run (R6, R9)
        set_card(2, 0, 32'h1AA, 32'h00FF8000, 3, 8'h00, 32'hC0FF8000, 8'h00);
        push_n(3, 6'd0, 32'h0, 1'b0);
        push(6'd8, 32'h1AA, 1'b0);
        push(6'd58, 32'h0, 1'b0);
        push_n(4, 6'd41, 32'h4000_0000, 1'b1);
        push(6'd58, 32'h0, 1'b0);
        push(6'd16, 32'd512, 1'b0);
        launch();
        chk(slow_clk_en == 1'b1, "R8 slow clock after start", 32'(slow_clk_en), 1);
        for (int i = 0; i < 2000 && cs_n; i++) @(negedge clk);
        repeat (5) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_end();
        expect_end("R6 high-capacity", 1'b1, 1'b0, 2'd0, 3'd3, 1'b1, 1'b0);
        repeat (20) @(negedge clk);
        chk(init_done == 1'b1, "R10 done held while idle", 32'(init_done), 1);

        // B: newer standard-capacity card, restart from done (R9)
        set_card(0, 0, 32'h1AA, 32'h00FF8000, 0, 8'h00, 32'h00FF8000, 8'h00);
        push(6'd0, 32'h0, 1'b0);
        push(6'd8, 32'h1AA, 1'b0);
        push(6'd58, 32'h0, 1'b0);
        push(6'd41, 32'h4000_0000, 1'b1);
        push(6'd58, 32'h0, 1'b0);
        push(6'd16, 32'd512, 1'b0);
        launch();
        chk(init_done == 1'b0 && slow_clk_en == 1'b1, "R9 restart clears done",
            {30'd0, init_done, slow_clk_en}, 32'h1);
        wait_end();
        expect_end("R6 standard v2", 1'b1, 1'b0, 2'd0, 3'd2, 1'b0, 1'b0);

        // C: legacy card
        set_card(0, 1, 32'h0, 32'h00FF8000, 1, 8'h00, 32'h0, 8'h00);
        push(6'd0, 32'h0, 1'b0);
        push(6'd8, 32'h1AA, 1'b0);
        push(6'd58, 32'h0, 1'b0);
        push_n(2, 6'd41, 32'h0, 1'b1);
        push(6'd16, 32'd512, 1'b0);
        launch();
        wait_end();
        expect_end("R6 legacy", 1'b1, 1'b0, 2'd0, 3'd1, 1'b0, 1'b0);

        // D: no device
        set_card(99, 0, 32'h1AA, 32'h00FF8000, 0, 8'h00, 32'h0, 8'h00);
        push_n(TRIES, 6'd0, 32'h0, 1'b0);
        launch();
        wait_end();
        expect_end("R2 no device", 1'b0, 1'b1, 2'd0, 3'd0, 1'b0, 1'b1);

        // E: bad echo
        set_card(0, 0, 32'h1A5, 32'h00FF8000, 0, 8'h00, 32'h0, 8'h00);
        push(6'd0, 32'h0, 1'b0);
        push(6'd8, 32'h1AA, 1'b0);
        launch();
        wait_end();
        expect_end("R3 echo mismatch", 1'b0, 1'b1, 2'd1, 3'd4, 1'b0, 1'b1);

        // F: no 3.3 V window
        set_card(0, 0, 32'h1AA, 32'h00EF8000, 0, 8'h00, 32'h0, 8'h00);
        push(6'd0, 32'h0, 1'b0);
        push(6'd8, 32'h1AA, 1'b0);
        push(6'd58, 32'h0, 1'b0);
        launch();
        wait_end();
        expect_end("R4 voltage window", 1'b0, 1'b1, 2'd1, 3'd4, 1'b0, 1'b1);

        // G: operating-condition timeout
        set_card(0, 0, 32'h1AA, 32'h00FF8000, -1, 8'h00, 32'h0, 8'h00);
        push(6'd0, 32'h0, 1'b0);
        push(6'd8, 32'h1AA, 1'b0);
        push(6'd58, 32'h0, 1'b0);
        push_n(POLL, 6'd41, 32'h4000_0000, 1'b1);
        launch();
        wait_end();
        expect_end("R5 poll timeout", 1'b0, 1'b1, 2'd2, 3'd4, 1'b0, 1'b1);

        // H: non-zero non-busy reply to operating condition
        set_card(0, 1, 32'h0, 32'h00FF8000, 0, 8'h04, 32'h0, 8'h00);
        push(6'd0, 32'h0, 1'b0);
        push(6'd8, 32'h1AA, 1'b0);
        push(6'd58, 32'h0, 1'b0);
        push(6'd41, 32'h0, 1'b1);
        launch();
        wait_end();
        expect_end("R5 error reply", 1'b0, 1'b1, 2'd3, 3'd4, 1'b0, 1'b1);

        // I: block-length command rejected
        set_card(0, 0, 32'h1AA, 32'h00FF8000, 0, 8'h00, 32'hC0FF8000, 8'h40);
        push(6'd0, 32'h0, 1'b0);
        push(6'd8, 32'h1AA, 1'b0);
        push(6'd58, 32'h0, 1'b0);
        push(6'd41, 32'h4000_0000, 1'b1);
        push(6'd58, 32'h0, 1'b0);
        push(6'd16, 32'd512, 1'b0);
        launch();
        wait_end();
        expect_end("R7 block length rejected", 1'b0, 1'b1, 2'd3, 3'd3, 1'b1, 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule